// File: doc/BRIEF.md
# Board Control Register Bank

A small memory-mapped bank of board housekeeping registers on a plain 32-bit register bus with address, write enable, write data and a registered read-data return. It provides a fixed identification word, a general-purpose LED register, two independent flag registers written through separate set and clear addresses, a display-control word whose low two bits steer an external pixel-format mux, a card-status word that mirrors two input pins, and a free-running tick counter that advances at a fixed rate derived from the system clock.

Reset control is guarded: the reset-level register only accepts a write while a 32-bit key value sits in the lock register. An accepted write with the trigger bit set emits a one-cycle reset-request pulse toward the chip's reset generator. Two reset inputs are used. The power-on reset clears everything. The soft reset clears all state except the retained flag register, which therefore carries information across a software-initiated restart.

A parameter selects between two board layouts. The layout moves the trigger bit of the reset-level register and the bit position of the write-protect status.

Top module: `brd_ctl_regs`

## Requirements
- R1: After reset, the LED register, lock, volatile flags and reset level read 0, the display word reads 0x0000_1F00, offset 0x00 reads the ID_WORD parameter, offset 0x44 reads 1 and the reset request is low.
- R2: Read data for the address presented at one rising edge appears on rdata after that edge. A write takes effect at the rising edge where wr_en is high.
- R3: A write to the lock register (0x20) of exactly 0x0000_A05F stores 0xA05F. Any other value stores its bits 14:0 with bit 15 cleared, so bit 15 reads 1 only when the key is held.
- R4: A write to the reset-level register (0x40) updates it only while the lock register holds 0xA05F. Otherwise the write is ignored.
- R5: An accepted reset-level write whose trigger bit is 1 drives rst_req high for exactly the cycle after the write edge. The trigger is bit 2 with ALT_LAYOUT=0 and bit 8 with ALT_LAYOUT=1. Without the trigger bit, no pulse occurs.
- R6: Volatile flags read at 0x30. A write to 0x30 ORs the data into them, and a write to 0x34 clears every bit that is 1 in the data.
- R7: Retained flags use the same scheme with set/read at 0x38 and clear at 0x3C. They are kept through sys_rst_n and cleared only by por_n.
- R8: The display word at 0x50 keeps bits 13:8 read-only and takes all other bits from a write. Output mux_sel equals bits 1:0 of the display word.
- R9: The card-status word at 0x48 has bit 0 equal to card_present. Bit 2 (ALT_LAYOUT=0) or bit 1 (ALT_LAYOUT=1) equals write_prot. All other bits are 0.
- R10: The tick counter at 0x5C advances by exactly one every CLK_PER_TICK clock cycles.
- R11: Unimplemented offsets such as 0x28 read 0, and writes to them or to 0x44 change no register.
- R12: The LED register at 0x08 stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears everything |
| sys_rst_n | input | 1 | Asynchronous active-low soft reset; clears all but retained flags |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| card_present | input | 1 | Card-detect status pin |
| write_prot | input | 1 | Card write-protect status pin |
| mux_sel | output | 2 | Pixel-format mux select from the display word |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that addresses are word aligned and that both resets are released synchronously to clk. They also assume that card_present and write_prot are already synchronous to clk and that wr_en is never X while out of reset. The stimulus changes every input only on the falling clock edge and always presents exact offsets. It releases por_n and sys_rst_n on a falling edge, so every property starts from a clean reset state and sees settled inputs at each rising edge.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
  localparam int unsigned DATA_W = 32;

  // Register offsets (byte addresses)
  localparam logic [11:0] OFF_ID      = 12'h000;
  localparam logic [11:0] OFF_LED     = 12'h008;
  localparam logic [11:0] OFF_LOCK    = 12'h020;
  localparam logic [11:0] OFF_FLG_SET = 12'h030;
  localparam logic [11:0] OFF_FLG_CLR = 12'h034;
  localparam logic [11:0] OFF_NVF_SET = 12'h038;
  localparam logic [11:0] OFF_NVF_CLR = 12'h03C;
  localparam logic [11:0] OFF_RSTLVL  = 12'h040;
  localparam logic [11:0] OFF_ONE     = 12'h044;
  localparam logic [11:0] OFF_CARD    = 12'h048;
  localparam logic [11:0] OFF_DISP    = 12'h050;
  localparam logic [11:0] OFF_TICK    = 12'h05C;

  localparam logic [15:0]       LOCK_KEY     = 16'hA05F;
  localparam logic [DATA_W-1:0] LOCK_KEY_W   = 32'h0000_A05F;
  localparam logic [DATA_W-1:0] DISP_RO_MASK = 32'h0000_3F00;
  localparam logic [DATA_W-1:0] DISP_RST     = 32'h0000_1F00;
endpackage

// File: rtl/brd_flag_bank.sv
module brd_flag_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q, flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (set_en)      flags_nxt = flags_q | wdata;
    else if (clr_en) flags_nxt = flags_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign flags_o = flags_q;

  // R6 R7
  set_bits_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((flags_q & $past(wdata)) == $past(wdata)));

  // R6 R7
  clr_bits_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((flags_q & $past(wdata)) == '0));
endmodule

// File: rtl/brd_reset_ctl.sv
module brd_reset_ctl
  import brd_ctl_pkg::*;
#(
  parameter int unsigned TRIG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic              lvl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       lock_o,
  output logic [DATA_W-1:0] level_o,
  output logic              req_o
);
  logic [15:0]       lock_q, lock_nxt;
  logic [DATA_W-1:0] level_q, level_nxt;
  logic              req_q, req_nxt;
  logic              unlocked;

  assign unlocked = (lock_q == LOCK_KEY);

  always_comb begin
    lock_nxt = lock_q;
    if (lock_wr) begin
      if (wdata == LOCK_KEY_W) lock_nxt = LOCK_KEY;
      else                     lock_nxt = {1'b0, wdata[14:0]};
    end
  end

  always_comb begin
    level_nxt = level_q;
    req_nxt   = 1'b0;
    if (lvl_wr && unlocked) begin
      level_nxt = wdata;
      req_nxt   = wdata[TRIG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      lock_q  <= lock_nxt;
      level_q <= level_nxt;
      req_q   <= req_nxt;
    end
  end

  assign lock_o  = lock_q;
  assign level_o = level_q;
  assign req_o   = req_q;

  // R3
  lock_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[15] |-> (lock_q == LOCK_KEY));

  // R4
  level_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(lock_q) == LOCK_KEY));

  // R5
  req_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(lvl_wr) && ($past(lock_q) == LOCK_KEY)));
endmodule

// File: rtl/brd_tick_gen.sv
module brd_tick_gen #(
  parameter int unsigned DIV = 5,
  parameter int unsigned CW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          adv;

  assign adv = (pre_q == PRE_LAST);

  always_comb begin
    pre_nxt = adv ? '0 : pre_q + 1'b1;
    cnt_nxt = adv ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign count_o = cnt_q;

  // R10
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R10
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
  import brd_ctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD      = 32'h1234_0A01,
  parameter bit          ALT_LAYOUT   = 1'b0,
  parameter int unsigned CLK_PER_TICK = 5,
  parameter int unsigned ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              card_present,
  input  logic              write_prot,
  output logic [1:0]        mux_sel,
  output logic              rst_req
);
  localparam int unsigned TRIG_BIT = ALT_LAYOUT ? 8 : 2;

  logic vol_rst_n;
  assign vol_rst_n = por_n & sys_rst_n;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic wr_led, wr_lock, wr_fset, wr_fclr, wr_nset, wr_nclr, wr_lvl, wr_disp;
  assign wr_led  = wr_en && hit(addr, OFF_LED);
  assign wr_lock = wr_en && hit(addr, OFF_LOCK);
  assign wr_fset = wr_en && hit(addr, OFF_FLG_SET);
  assign wr_fclr = wr_en && hit(addr, OFF_FLG_CLR);
  assign wr_nset = wr_en && hit(addr, OFF_NVF_SET);
  assign wr_nclr = wr_en && hit(addr, OFF_NVF_CLR);
  assign wr_lvl  = wr_en && hit(addr, OFF_RSTLVL);
  assign wr_disp = wr_en && hit(addr, OFF_DISP);

  // LED and display registers
  logic [31:0] led_q, led_nxt, disp_q, disp_nxt;

  always_comb begin
    led_nxt  = wr_led ? wdata : led_q;
    disp_nxt = wr_disp ? ((disp_q & DISP_RO_MASK) | (wdata & ~DISP_RO_MASK)) : disp_q;
  end

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      led_q  <= '0;
      disp_q <= DISP_RST;
    end else begin
      led_q  <= led_nxt;
      disp_q <= disp_nxt;
    end
  end

  assign mux_sel = disp_q[1:0];

  // Flag registers: one volatile, one retained across soft reset
  logic [31:0] flags_v, flags_r;

  brd_flag_bank #(.W(DATA_W)) u_flags_vol (
    .clk(clk), .rst_n(vol_rst_n), .set_en(wr_fset), .clr_en(wr_fclr),
    .wdata(wdata), .flags_o(flags_v)
  );

  brd_flag_bank #(.W(DATA_W)) u_flags_ret (
    .clk(clk), .rst_n(por_n), .set_en(wr_nset), .clr_en(wr_nclr),
    .wdata(wdata), .flags_o(flags_r)
  );

  // Lock and guarded reset level
  logic [15:0] lock_val;
  logic [31:0] level_val;

  brd_reset_ctl #(.TRIG_BIT(TRIG_BIT)) u_rstctl (
    .clk(clk), .rst_n(vol_rst_n), .lock_wr(wr_lock), .lvl_wr(wr_lvl),
    .wdata(wdata), .lock_o(lock_val), .level_o(level_val), .req_o(rst_req)
  );

  // Tick counter
  logic [31:0] tick_val;

  brd_tick_gen #(.DIV(CLK_PER_TICK), .CW(DATA_W)) u_tick (
    .clk(clk), .rst_n(vol_rst_n), .count_o(tick_val)
  );

  // Card status word, layout chosen by parameter
  logic [31:0] card_word;
  generate
    if (ALT_LAYOUT) begin : g_card_alt
      assign card_word = {29'd0, 1'b0, write_prot, card_present};
    end else begin : g_card_std
      assign card_word = {29'd0, write_prot, 1'b0, card_present};
    end
  endgenerate

  // Registered read mux
  logic [31:0] rd_q, rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if      (hit(addr, OFF_ID))      rd_nxt = ID_WORD;
    else if (hit(addr, OFF_LED))     rd_nxt = led_q;
    else if (hit(addr, OFF_LOCK))    rd_nxt = {16'd0, lock_val};
    else if (hit(addr, OFF_FLG_SET)) rd_nxt = flags_v;
    else if (hit(addr, OFF_NVF_SET)) rd_nxt = flags_r;
    else if (hit(addr, OFF_RSTLVL))  rd_nxt = level_val;
    else if (hit(addr, OFF_ONE))     rd_nxt = 32'd1;
    else if (hit(addr, OFF_CARD))    rd_nxt = card_word;
    else if (hit(addr, OFF_DISP))    rd_nxt = disp_q;
    else if (hit(addr, OFF_TICK))    rd_nxt = tick_val;
  end

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) rd_q <= '0;
    else            rd_q <= rd_nxt;
  end

  assign rdata = rd_q;

  // R8
  disp_ro_field_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    $stable(disp_q[13:8]));

  // R12
  led_hold_chk: assert property (@(posedge clk) disable iff (!vol_rst_n)
    !wr_led |=> $stable(led_q));
endmodule

// File: tb/sim_brd_ctl_regs.sv
`timescale 1ns/1ps
module sim_brd_ctl_regs;
  logic        clk = 1'b0;
  logic        por_n, sys_rst_n;
  logic [11:0] addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        card_present, write_prot;
  logic [1:0]  mux_sel;
  logic        rst_req;

  int errors = 0;
  int checks = 0;

  localparam logic [31:0] ID_EXP = 32'h1234_0A01;

  always #4 clk = ~clk;

  brd_ctl_regs u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .card_present(card_present),
    .write_prot(write_prot), .mux_sel(mux_sel), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  // {do_write, write addr, write data, read addr, expected, requirement number}
  localparam int NV = 17;
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0,         12'h000, 32'h1234_0A01, 8'd1},  // R1 ID
    {1'b0, 12'h000, 32'h0,         12'h044, 32'h0000_0001, 8'd1},  // R1 constant one
    {1'b1, 12'h008, 32'hDEAD_BEEF, 12'h008, 32'hDEAD_BEEF, 8'd12}, // R12
    {1'b1, 12'h030, 32'h0000_00F0, 12'h030, 32'h0000_00F0, 8'd6},  // R6 set
    {1'b1, 12'h030, 32'h0F00_0001, 12'h030, 32'h0F00_00F1, 8'd6},  // R6 OR
    {1'b1, 12'h034, 32'h0000_0030, 12'h030, 32'h0F00_00C1, 8'd6},  // R6 clear
    {1'b1, 12'h038, 32'h0000_00A5, 12'h038, 32'h0000_00A5, 8'd7},  // R7 set
    {1'b1, 12'h03C, 32'h0000_0005, 12'h038, 32'h0000_00A0, 8'd7},  // R7 clear
    {1'b1, 12'h020, 32'h0000_FFFF, 12'h020, 32'h0000_7FFF, 8'd3},  // R3 non-key
    {1'b1, 12'h040, 32'h0000_0003, 12'h040, 32'h0000_0000, 8'd4},  // R4 locked
    {1'b1, 12'h020, 32'h0000_A05F, 12'h020, 32'h0000_A05F, 8'd3},  // R3 key
    {1'b1, 12'h040, 32'h0000_0011, 12'h040, 32'h0000_0011, 8'd4},  // R4 unlocked
    {1'b1, 12'h050, 32'hFFFF_FFFF, 12'h050, 32'hFFFF_DFFF, 8'd8},  // R8
    {1'b1, 12'h050, 32'h0000_0002, 12'h050, 32'h0000_1F02, 8'd8},  // R8
    {1'b1, 12'h028, 32'h0000_1234, 12'h028, 32'h0000_0000, 8'd11}, // R11 reads zero
    {1'b0, 12'h000, 32'h0,         12'h008, 32'hDEAD_BEEF, 8'd11}, // R11 no side effect
    {1'b1, 12'h044, 32'h0000_0000, 12'h044, 32'h0000_0001, 8'd11}  // R11 constant kept
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    por_n = 1'b0; sys_rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0;
    card_present = 1'b0; write_prot = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;

    // R1 reset state
    check("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(12'h008, v); check("R1 led", v, 32'd0);
    rd(12'h020, v); check("R1 lock", v, 32'd0);
    rd(12'h030, v); check("R1 flags", v, 32'd0);
    rd(12'h040, v); check("R1 level", v, 32'd0);
    rd(12'h050, v); check("R1 display", v, 32'h0000_1F00);
    check("R8 mux reset", {30'd0, mux_sel}, 32'd0);

    // R2: read data arrives after exactly one edge
    @(negedge clk); addr = 12'h000;
    @(negedge clk); check("R2 latency", rdata, ID_EXP);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][96]) wr(VEC[i][95:84], VEC[i][83:52]);
      rd(VEC[i][51:40], v);
      check($sformatf("R%0d vec%0d", VEC[i][7:0], i), v, VEC[i][39:8]);
    end
    check("R8 mux_sel", {30'd0, mux_sel}, 32'd2);

    // R5: trigger pulse, lock holds key from table
    @(negedge clk); addr = 12'h040; wdata = 32'h0000_0004; wr_en = 1'b1;
    check("R5 no early pulse", {31'd0, rst_req}, 32'd0);
    @(negedge clk); wr_en = 1'b0;
    check("R5 pulse high", {31'd0, rst_req}, 32'd1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, rst_req}, 32'd0);
    // R5: bit 8 is not the trigger in the default layout
    @(negedge clk); addr = 12'h040; wdata = 32'h0000_0100; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R5 bit8 no pulse", {31'd0, rst_req}, 32'd0);
    rd(12'h040, v); check("R4 level stored", v, 32'h0000_0100);
    // R4: relock, write ignored and no pulse
    wr(12'h020, 32'h0000_1234);
    @(negedge clk); addr = 12'h040; wdata = 32'h0000_0004; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R4 locked no pulse", {31'd0, rst_req}, 32'd0);
    rd(12'h040, v); check("R4 locked ignored", v, 32'h0000_0100);

    // R9 card status
    card_present = 1'b1; write_prot = 1'b1;
    rd(12'h048, v); check("R9 both", v, 32'h0000_0005);
    card_present = 1'b0;
    rd(12'h048, v); check("R9 wp only", v, 32'h0000_0004);
    card_present = 1'b1; write_prot = 1'b0;
    rd(12'h048, v); check("R9 card only", v, 32'h0000_0001);

    // R10 tick rate
    @(negedge clk); addr = 12'h05C;
    @(negedge clk); v = rdata;
    repeat (50) @(negedge clk);
    v2 = rdata;
    check("R10 tick delta", v2 - v, 32'd10);

    // R7 soft reset keeps retained flags
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk); sys_rst_n = 1'b1;
    rd(12'h038, v); check("R7 retained", v, 32'h0000_00A0);
    rd(12'h030, v); check("R1 flags soft", v, 32'd0);
    rd(12'h008, v); check("R1 led soft", v, 32'd0);
    rd(12'h050, v); check("R1 display soft", v, 32'h0000_1F00);
    rd(12'h020, v); check("R1 lock soft", v, 32'd0);

    // R7 power-on reset clears retained flags
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    rd(12'h038, v); check("R7 por clears", v, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule